// File: doc/BRIEF.md
# Multi-Port Pixel Deserializer

This block sits behind the differential receivers of an area image sensor that sends each row on five parallel ports. Every port has three lanes. Each lane sends one nibble of a 12-bit pixel serially, least significant bit first, one bit per clock. A shared alignment strobe marks the clock on which the last bit of every nibble is present. The block rebuilds one pixel per port for each strobe. It stores the whole row in a ping-pong line buffer. It then emits the row as a single stream in ascending column order, with row and column indices and line-start and frame-start flags attached.

Two sync inputs frame the data. A rising edge on the line sync opens a row and restarts column counting. A rising edge on the frame sync restarts row numbering. A mode input selects full 12-bit pixels or narrow 10-bit pixels. While a row is being received, the block watches the alignment strobe and raises a sticky error if the strobe comes early or fails to come.

Top module: `pixel_deser`

## Requirements
- R1: Port p, lane l is input bit `laneBits[3*p+l]`. Lane l carries pixel bits 4l to 4l+3, and the first bit sent is bit 4l.
- R2: The nibble is complete on the clock where `align` is high. That clock carries the most significant bit of the nibble on every lane.
- R3: With `fastMode` low, all 12 pixel bits pass to `pixData` unchanged.
- R4: With `fastMode` high during capture, pixel bits 11 and 10 are dropped and `pixData` is zero-extended from 10 bits.
- R5: The pixel at local column c of port p (0-based) is output with `pixCol` = p*PORT_COLS + c, so port A holds the lowest columns and port E the highest.
- R6: A completed row leaves as one burst with `pixValid` high on consecutive clocks. Within the burst, `pixCol` rises by one per clock from 0 to 5*PORT_COLS-1.
- R7: `lineStart` is high only with the column-0 pixel of each row. `frameStart` is high only with the column-0 pixel of the first row completed after a frame-sync rising edge.
- R8: `pixRow` is 0 for the first row completed after a frame-sync rising edge and rises by one for each later completed row. It is constant within a row.
- R9: A line-sync rising edge restarts column counting at 0. Any partly received row is discarded and produces no output.
- R10: Alignment strobes outside an open row are ignored and produce no output. This covers strobes before the first line-sync edge and strobes after a row's last column.
- R11: While a row is open, and after its first strobe, the strobe must recur exactly every 4 clocks. An early strobe or a missing strobe sets `alignErr`, which stays high until the next line-sync rising edge clears it.
- R12: While `rstN` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; lanes are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| laneBits | input | 15 | Serial lane bits, three per port, port A lowest |
| align | input | 1 | Nibble boundary strobe, high with the last bit |
| lineSync | input | 1 | Row sync; its rising edge opens a row |
| frameSync | input | 1 | Frame sync; its rising edge restarts row numbering |
| fastMode | input | 1 | High selects 10-bit pixels |
| pixValid | output | 1 | Output pixel qualifier |
| pixData | output | 12 | Reassembled pixel value |
| pixRow | output | 11 | Row index within the frame |
| pixCol | output | 11 | Column index within the row |
| lineStart | output | 1 | First pixel of a row |
| frameStart | output | 1 | First pixel of a frame |
| alignErr | output | 1 | Sticky strobe-spacing error |

## Verification
Several faults look the same at the ports: a lane mapped to the wrong port, a nibble shifted by one bit, or a wrong bank select. Each corrupts `pixData` or `pixCol` on the first pixel of the affected row, about two clocks after that row's last strobe. A column counter that is not restarted shows up as lost or duplicated output rows. A row counter that is not restarted shows up as a wrong `pixRow` on the first row of the next frame. The strobe-spacing tracker is compared against a model on every clock, so an off-by-one in its gap count flags `alignErr` one clock early or late.

// File: rtl/pixdes_pkg.sv
package pixdes_pkg;
  localparam int LANE_BITS = 4;
  localparam int LANES     = 3;
  localparam int PIX_W     = LANE_BITS * LANES;

  // strobes handed from control to datapath each clock
  typedef struct packed {
    logic capEn;    // write the assembled pixels of all ports
    logic capBank;  // line buffer bank being filled
    logic rdEn;     // read one pixel for output
    logic rdBank;   // line buffer bank being drained
  } pdStrobe_t;
endpackage

// File: rtl/pixdes_ctrl.sv
module pixdes_ctrl
  import pixdes_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int PORT_COLS = 256,
  parameter int ROW_W     = 11,
  parameter int COL_OUT_W = $clog2(NUM_PORTS * PORT_COLS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 align,
  input  logic                 lineSync,
  input  logic                 frameSync,
  output pdStrobe_t            strobe,
  output logic [$clog2(PORT_COLS)-1:0] capCol,
  output logic [((NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1)-1:0] rdPort,
  output logic [$clog2(PORT_COLS)-1:0] rdCol,
  output logic                 pixValid,
  output logic [ROW_W-1:0]     pixRow,
  output logic [COL_OUT_W-1:0] pixCol,
  output logic                 lineStart,
  output logic                 frameStart,
  output logic                 alignErr
);
  localparam int COL_W  = $clog2(PORT_COLS);
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int GAP_W  = $clog2(LANE_BITS);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(LANE_BITS - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(PORT_COLS - 1);
  localparam logic [PORT_W-1:0] PORT_LAST = PORT_W'(NUM_PORTS - 1);

  logic lsQ, fsQ, lsRise, fsRise;
  logic lineActive, haveAlign;
  logic [GAP_W-1:0] gapCnt;
  logic [COL_W-1:0] colCnt;
  logic capBank;
  logic [ROW_W-1:0] rowCnt;
  logic framePend;
  logic [ROW_W-1:0] rowMeta [2];
  logic frameMeta [2];
  logic emitBusy, emitBank;
  logic [PORT_W-1:0] emitPort;
  logic [COL_W-1:0] emitCol;
  logic capFire, lineDone, emitFirst, emitLast;

  assign lsRise    = lineSync & ~lsQ;
  assign fsRise    = frameSync & ~fsQ;
  assign capFire   = lineActive & ~lsRise & align;
  assign lineDone  = capFire & (colCnt == COL_LAST);
  assign emitFirst = emitBusy & (emitPort == '0) & (emitCol == '0);
  assign emitLast  = (emitPort == PORT_LAST) & (emitCol == COL_LAST);

  always_comb begin
    strobe.capEn   = capFire;
    strobe.capBank = capBank;
    strobe.rdEn    = emitBusy;
    strobe.rdBank  = emitBank;
    capCol         = colCnt;
    rdPort         = emitPort;
    rdCol          = emitCol;
  end

  // sync edges, row window and strobe spacing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lsQ        <= 1'b0;
      fsQ        <= 1'b0;
      lineActive <= 1'b0;
      haveAlign  <= 1'b0;
      gapCnt     <= '0;
      colCnt     <= '0;
      alignErr   <= 1'b0;
    end else begin
      lsQ <= lineSync;
      fsQ <= frameSync;
      if (lsRise) begin
        lineActive <= 1'b1;
        colCnt     <= '0;
        haveAlign  <= 1'b0;
        gapCnt     <= '0;
        alignErr   <= 1'b0;
      end else if (lineActive) begin
        if (align) begin
          if (haveAlign && gapCnt != GAP_LAST) alignErr <= 1'b1;
          gapCnt    <= '0;
          haveAlign <= 1'b1;
          colCnt    <= colCnt + 1'b1;
          if (colCnt == COL_LAST) lineActive <= 1'b0;
        end else if (haveAlign) begin
          if (gapCnt == GAP_LAST) alignErr <= 1'b1;
          gapCnt <= gapCnt + 1'b1;
        end
      end
    end
  end

  // row numbering, bank ownership, per-bank row tags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capBank      <= 1'b0;
      rowCnt       <= '0;
      framePend    <= 1'b0;
      rowMeta[0]   <= '0;
      rowMeta[1]   <= '0;
      frameMeta[0] <= 1'b0;
      frameMeta[1] <= 1'b0;
    end else begin
      if (lineDone) begin
        capBank            <= ~capBank;
        rowMeta[capBank]   <= rowCnt;
        frameMeta[capBank] <= framePend;
        rowCnt             <= rowCnt + 1'b1;
        framePend          <= 1'b0;
      end
      if (fsRise) begin
        rowCnt    <= '0;
        framePend <= 1'b1;
      end
    end
  end

  // emitter: walks port A..E, column 0..last, one pixel per clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      emitBusy <= 1'b0;
      emitBank <= 1'b0;
      emitPort <= '0;
      emitCol  <= '0;
    end else if (lineDone) begin
      emitBusy <= 1'b1;
      emitBank <= capBank;
      emitPort <= '0;
      emitCol  <= '0;
    end else if (emitBusy) begin
      if (emitLast) begin
        emitBusy <= 1'b0;
        emitPort <= '0;
        emitCol  <= '0;
      end else if (emitCol == COL_LAST) begin
        emitCol  <= '0;
        emitPort <= emitPort + 1'b1;
      end else begin
        emitCol <= emitCol + 1'b1;
      end
    end
  end

  // output tags, aligned with the registered buffer read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixValid   <= 1'b0;
      pixRow     <= '0;
      pixCol     <= '0;
      lineStart  <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      pixValid   <= emitBusy;
      lineStart  <= emitFirst;
      frameStart <= emitFirst & frameMeta[emitBank];
      if (emitBusy) begin
        pixRow <= rowMeta[emitBank];
        pixCol <= COL_OUT_W'(emitPort) * COL_OUT_W'(PORT_COLS) + COL_OUT_W'(emitCol);
      end else begin
        pixRow <= '0;
        pixCol <= '0;
      end
    end
  end
endmodule

// File: rtl/pixdes_datapath.sv
module pixdes_datapath
  import pixdes_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int PORT_COLS = 256,
  parameter int NARROW_W  = 10
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_PORTS*LANES-1:0]    laneBits,
  input  logic                          fastMode,
  input  pdStrobe_t                     strobe,
  input  logic [$clog2(PORT_COLS)-1:0]  capCol,
  input  logic [((NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1)-1:0] rdPort,
  input  logic [$clog2(PORT_COLS)-1:0]  rdCol,
  output logic [PIX_W-1:0]              pixData
);
  localparam int NUM_LANES = NUM_PORTS * LANES;
  localparam int HIST_W    = LANE_BITS - 1;
  localparam logic [PIX_W-1:0] NARROW_MASK = PIX_W'((1 << NARROW_W) - 1);

  logic [HIST_W-1:0]    hist     [NUM_LANES];
  logic [LANE_BITS-1:0] laneWord [NUM_LANES];
  logic [PIX_W-1:0]     rawPix   [NUM_PORTS];
  logic [PIX_W-1:0]     capPix   [NUM_PORTS];
  logic [PIX_W-1:0]     lineMem  [2][NUM_PORTS][PORT_COLS];

  // per lane: earlier bits sit in the history, the newest bit is the MSB
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) hist[i] <= '0;
      else       hist[i] <= {laneBits[i], hist[i][HIST_W-1:1]};
    end
    assign laneWord[i] = {laneBits[i], hist[i]};
  end

  // per port: lane l supplies nibble l of the pixel
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar l = 0; l < LANES; l++) begin : g_nib
      assign rawPix[p][l*LANE_BITS +: LANE_BITS] = laneWord[p*LANES + l];
    end
    assign capPix[p] = fastMode ? (rawPix[p] & NARROW_MASK) : rawPix[p];
  end

  always_ff @(posedge clk) begin
    if (strobe.capEn) begin
      for (int p = 0; p < NUM_PORTS; p++)
        lineMem[strobe.capBank][p][capCol] <= capPix[p];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pixData <= '0;
    else if (strobe.rdEn) pixData <= lineMem[strobe.rdBank][rdPort][rdCol];
    else                  pixData <= '0;
  end
endmodule

// File: rtl/pixel_deser.sv
module pixel_deser
  import pixdes_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int PORT_COLS = 256,
  parameter int ROW_W     = 11,
  parameter int NARROW_W  = 10,
  parameter int COL_OUT_W = $clog2(NUM_PORTS * PORT_COLS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PORTS*LANES-1:0] laneBits,
  input  logic                       align,
  input  logic                       lineSync,
  input  logic                       frameSync,
  input  logic                       fastMode,
  output logic                       pixValid,
  output logic [PIX_W-1:0]           pixData,
  output logic [ROW_W-1:0]           pixRow,
  output logic [COL_OUT_W-1:0]       pixCol,
  output logic                       lineStart,
  output logic                       frameStart,
  output logic                       alignErr
);
  localparam int COL_W  = $clog2(PORT_COLS);
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  pdStrobe_t         strobe;
  logic [COL_W-1:0]  capCol, rdCol;
  logic [PORT_W-1:0] rdPort;

  pixdes_ctrl #(
    .NUM_PORTS(NUM_PORTS), .PORT_COLS(PORT_COLS),
    .ROW_W(ROW_W), .COL_OUT_W(COL_OUT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .align(align), .lineSync(lineSync),
    .frameSync(frameSync), .strobe(strobe), .capCol(capCol),
    .rdPort(rdPort), .rdCol(rdCol), .pixValid(pixValid),
    .pixRow(pixRow), .pixCol(pixCol), .lineStart(lineStart),
    .frameStart(frameStart), .alignErr(alignErr)
  );

  pixdes_datapath #(
    .NUM_PORTS(NUM_PORTS), .PORT_COLS(PORT_COLS), .NARROW_W(NARROW_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .laneBits(laneBits), .fastMode(fastMode),
    .strobe(strobe), .capCol(capCol), .rdPort(rdPort), .rdCol(rdCol),
    .pixData(pixData)
  );
endmodule

// File: rtl/pixel_deser_chk.sv
module pixel_deser_chk #(
  parameter int NUM_PORTS = 5,
  parameter int PORT_COLS = 256,
  parameter int ROW_W     = 11,
  parameter int COL_OUT_W = 11
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 lineSync,
  input logic                 pixValid,
  input logic [ROW_W-1:0]     pixRow,
  input logic [COL_OUT_W-1:0] pixCol,
  input logic                 lineStart,
  input logic                 frameStart,
  input logic                 alignErr
);
  AST_COL_IN_ROW: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> (int'(pixCol) < NUM_PORTS * PORT_COLS)); // R5

  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && $past(pixValid) && !lineStart) |-> (pixCol == $past(pixCol) + 1'b1)); // R6

  AST_LINE_AT_COL0: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && lineStart) |-> (pixCol == '0)); // R7

  AST_FRAME_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (lineStart && pixValid && pixRow == '0)); // R7

  AST_FLAGS_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |-> (!lineStart && !frameStart)); // R7

  AST_ROW_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && $past(pixValid) && !lineStart) |-> (pixRow == $past(pixRow))); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (alignErr && !(lineSync && !$past(lineSync))) |=> alignErr); // R11
endmodule

bind pixel_deser pixel_deser_chk #(
  .NUM_PORTS(NUM_PORTS), .PORT_COLS(PORT_COLS),
  .ROW_W(ROW_W), .COL_OUT_W(COL_OUT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .lineSync(lineSync), .pixValid(pixValid),
  .pixRow(pixRow), .pixCol(pixCol), .lineStart(lineStart),
  .frameStart(frameStart), .alignErr(alignErr)
);

// File: tb/sim_pixel_deser.sv
module sim_pixel_deser;
  localparam int NP = 5;
  localparam int PC = 8;
  localparam int RW = 11;
  localparam int CW = $clog2(NP * PC);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, align, lineSync, frameSync, fastMode;
  logic [NP*3-1:0] laneBits;
  logic pixValid, lineStart, frameStart, alignErr;
  logic [11:0] pixData;
  logic [RW-1:0] pixRow;
  logic [CW-1:0] pixCol;

  pixel_deser #(.NUM_PORTS(NP), .PORT_COLS(PC), .ROW_W(RW), .NARROW_W(10)) u0 (
    .clk(clk), .rstN(rstN), .laneBits(laneBits), .align(align),
    .lineSync(lineSync), .frameSync(frameSync), .fastMode(fastMode),
    .pixValid(pixValid), .pixData(pixData), .pixRow(pixRow), .pixCol(pixCol),
    .lineStart(lineStart), .frameStart(frameStart), .alignErr(alignErr)
  );

  typedef struct { int data; int row; int col; bit ls; bit fs; } expPix_t;
  expPix_t expQ[$];

  int checks = 0, fails = 0;
  int rowNo = 0;
  bit framePend = 1'b0;
  bit done = 1'b0;

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int pv(int line, int p, int c);
    return (line * 149 + p * 733 + c * 91 + 17) % 4096;
  endfunction

  // behavioural model of the row window and strobe spacing
  bit mActive = 0, mHave = 0, mErr = 0, mLsPrev = 0;
  int mGap = 0, mCol = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      mActive = 0; mHave = 0; mErr = 0; mLsPrev = 0; mGap = 0; mCol = 0;
    end else begin
      if (lineSync && !mLsPrev) begin
        mActive = 1; mHave = 0; mErr = 0; mGap = 0; mCol = 0;
      end else if (mActive) begin
        if (align) begin
          if (mHave && mGap != 3) mErr = 1;
          mGap = 0; mHave = 1; mCol++;
          if (mCol == PC) mActive = 0;
        end else if (mHave) begin
          if (mGap == 3) mErr = 1;
          mGap = (mGap + 1) % 4;
        end
      end
      mLsPrev = lineSync;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(alignErr == mErr, "R11", "alignErr", int'(alignErr), int'(mErr));
      if (pixValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R10", "unexpected pixel at col", int'(pixCol), -1);
        end else begin
          expPix_t e;
          e = expQ.pop_front();
          check(int'(pixData) == e.data, "R1/R3/R4", "pixData", int'(pixData), e.data);
          check(int'(pixCol) == e.col, "R5/R6", "pixCol", int'(pixCol), e.col);
          check(int'(pixRow) == e.row, "R8", "pixRow", int'(pixRow), e.row);
          check(lineStart == e.ls, "R7", "lineStart", int'(lineStart), int'(e.ls));
          check(frameStart == e.fs, "R7", "frameStart", int'(frameStart), int'(e.fs));
        end
      end
    end
  end

  task automatic idle(int n);
    align = 0; laneBits = '0;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseLine();
    lineSync = 1; @(negedge clk); lineSync = 0;
  endtask

  task automatic pulseFrame();
    frameSync = 1; @(negedge clk); frameSync = 0;
    rowNo = 0; framePend = 1;
  endtask

  // R2: first bit of each lane word is bit 4l, align rides with the fourth
  task automatic sendWords(int line, int ncols);
    for (int c = 0; c < ncols; c++) begin
      for (int k = 0; k < 4; k++) begin
        for (int p = 0; p < NP; p++) begin
          int v;
          v = pv(line, p, c);
          for (int l = 0; l < 3; l++) laneBits[p*3 + l] = v[4*l + k];
        end
        align = (k == 3);
        @(negedge clk);
      end
    end
    align = 0; laneBits = '0;
  endtask

  task automatic sendLine(int line, bit fast);
    fastMode = fast;
    pulseLine();
    sendWords(line, PC);
    for (int p = 0; p < NP; p++)
      for (int c = 0; c < PC; c++) begin
        expPix_t e;
        e.data = fast ? (pv(line, p, c) & 12'h3FF) : pv(line, p, c);
        e.col  = p * PC + c;
        e.row  = rowNo;
        e.ls   = (p == 0 && c == 0);
        e.fs   = (p == 0 && c == 0) && framePend;
        expQ.push_back(e);
      end
    rowNo++; framePend = 0;
    idle(60);
    fastMode = 0;
  endtask

  task automatic junkAligns(int n);
    for (int i = 0; i < n; i++) begin
      laneBits = 15'h5A3C ^ 15'(i * 977);
      align = (i % 4 == 3);
      @(negedge clk);
    end
    align = 0; laneBits = '0;
  endtask

  initial begin
    rstN = 0; align = 0; lineSync = 0; frameSync = 0; fastMode = 0; laneBits = '0;
    repeat (4) @(negedge clk);
    // R12 reset state
    check(!pixValid && pixData == 0 && pixRow == 0 && pixCol == 0 &&
          !lineStart && !frameStart && !alignErr, "R12", "outputs in reset",
          int'({pixValid, lineStart, frameStart, alignErr}), 0);
    rstN = 1;
    idle(3);

    junkAligns(24);                 // R10: no row open yet
    idle(10);

    pulseFrame();
    sendLine(1, 0);                 // R1 R3 R5 R6 R7 R8: row 0 with frame flag
    sendLine(2, 0);                 // R8: row 1
    junkAligns(24);                 // R10: strobes after the last column
    idle(10);
    sendLine(3, 1);                 // R4: narrow pixels

    // R9: partial row, then a fresh line-sync edge
    pulseLine();
    sendWords(9, 3);
    sendLine(4, 0);

    // R11: early strobe
    pulseLine();
    sendWords(5, 2);
    laneBits = '0; align = 0; @(negedge clk);
    align = 1; @(negedge clk);
    align = 0; idle(3);
    check(alignErr == 1'b1, "R11", "early strobe flag", int'(alignErr), 1);

    // R11: missing strobe
    pulseLine();
    check(alignErr == 1'b0, "R11", "cleared by line sync", int'(alignErr), 0);
    sendWords(6, 1);
    idle(6);
    check(alignErr == 1'b1, "R11", "missing strobe flag", int'(alignErr), 1);

    sendLine(7, 0);                 // R9: clean row after aborted ones
    pulseFrame();
    sendLine(8, 0);                 // R7 R8: new frame restarts rows
    sendLine(10, 1);

    idle(80);
    check(expQ.size() == 0, "R6", "pixels never emitted", expQ.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", expQ.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule